// File: doc/BRIEF.md
# Store Drain Buffer with Read Bypass

This block sits between a write-through data cache and the next memory level. Every store the processor writes into the cache is also handed to this buffer. The buffer keeps it in a small queue and later writes it to memory, so the processor never waits for the memory write. Stores leave the queue one at a time and in arrival order, over a single request/acknowledge memory port.

Read misses from the cache use a separate read port. A read may overtake stores that are still queued. Before it overtakes them, its word address is compared against every occupied queue slot. A build-time parameter selects how a match is handled:
- In forwarding mode the read goes to memory at once. Its returned word is patched byte by byte with the queued store data, and the youngest matching store wins each byte.
- In drain mode the read is held back until every matching store has been acknowledged by memory.

The memory port serves one requester at a time. While a read is outstanding, no store is issued.

Top module: `store_drain_buffer`

## Requirements
- R1: After reset the queue is empty, `st_ready` is 1, `mem_req` is 0 and `rd_done` is 0.
- R2: A store is taken when `st_valid` and `st_ready` are both 1 in the same cycle. Up to DEPTH stores are held while memory is not acknowledging.
- R3: With DEPTH entries held, `st_ready` is 0 and the queue never exceeds DEPTH. `st_ready` returns to 1 in the cycle after the first memory acknowledge.
- R4: Queued stores are written to memory in acceptance order. Each write has `mem_we`=1 and carries the stored address, data and byte enables; byte enable bit b covers data bits 8b+7..8b.
- R5: An issued memory request keeps `mem_req`, `mem_addr` and `mem_we` unchanged until `mem_ack`. An entry leaves the queue only in the cycle its write is acknowledged.
- R6: A pending read is issued to memory as soon as the port is idle. It goes ahead of queued stores it does not have to wait for. A store that was already issued finishes first.
- R7: While a read is outstanding, no store is issued and the queue head does not move. Store writes resume after the read completes.
- R8: Forwarding mode (FORWARD=1): the read does not wait for matching stores. For each byte, `rd_data` takes that byte from the youngest store that was queued when the read was issued, has the same word address, and has that byte enabled. Bytes with no such store come from `mem_rdata`.
- R9: Drain mode (FORWARD=0): a read whose address matches any queued store is not issued until all matching stores have been acknowledged. Its data is then the memory word.
- R10: `rd_done` is 1 for exactly the one cycle in which memory acknowledges the read. `rd_data` is valid in that cycle. `rd_addr` must be held while `rd_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request present |
| st_ready | output | 1 | Buffer can take a store |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| st_be | input | DW/8 | Store byte enables |
| rd_valid | input | 1 | Read miss pending; held until `rd_done` |
| rd_addr | input | AW | Read word address |
| rd_done | output | 1 | Read data returned this cycle |
| rd_data | output | DW | Read data, merged with queued stores when forwarding |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 for a store write, 0 for a read |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Write data |
| mem_be | output | DW/8 | Write byte enables (all ones on reads) |
| mem_ack | input | 1 | Memory completes the current request |
| mem_rdata | input | DW | Memory read data, valid with `mem_ack` |

## Verification
A corrupted head or tail pointer shows up at the memory port on the next issued write: the address or data appears out of order, or an entry appears twice. A wrong occupancy count shows up as `st_ready` differing from the number of unacknowledged stores as soon as the queue reaches full. A faulty match or age decision appears only at the cycle the read is acknowledged. It shows either as a wrong byte in `rd_data` or as a read ordered differently against the write stream than the policy allows. For that reason, every read scenario checks both the returned word and how many writes memory completed before the read.

// File: rtl/sdb_pkg.sv
package sdb_pkg;

  typedef enum logic [1:0] {
    PORT_IDLE = 2'd0,
    PORT_WR   = 2'd1,
    PORT_RD   = 2'd2
  } port_st_e;

  // Distance of slot idx from the oldest slot; larger means younger.
  function automatic int unsigned ring_age(input int unsigned idx,
                                           input int unsigned head,
                                           input int unsigned depth);
    return (idx + depth - head) % depth;
  endfunction

endpackage

// File: rtl/sdb_fifo.sv
module sdb_fifo #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int BW   = DW / 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      push,
  input  logic [AW-1:0]             push_addr,
  input  logic [DW-1:0]             push_data,
  input  logic [BW-1:0]             push_be,
  input  logic                      pop,
  output logic                      full,
  output logic                      empty,
  output logic [PW-1:0]             head_idx,
  output logic [DEPTH-1:0]          ent_valid,
  output logic [DEPTH-1:0][AW-1:0]  ent_addr,
  output logic [DEPTH-1:0][DW-1:0]  ent_data,
  output logic [DEPTH-1:0][BW-1:0]  ent_be,
  output logic [AW-1:0]             head_addr,
  output logic [DW-1:0]             head_data,
  output logic [BW-1:0]             head_be
);

  logic [PW-1:0]    head_q, tail_q;
  logic [CW-1:0]    count_q;
  logic [DEPTH-1:0] valid_q;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
      valid_q <= '0;
    end else begin
      if (push) begin
        valid_q[tail_q] <= 1'b1;
        tail_q          <= ptr_inc(tail_q);
      end
      if (pop) begin
        valid_q[head_q] <= 1'b0;
        head_q          <= ptr_inc(head_q);
      end
      count_q <= count_q + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      ent_addr[tail_q] <= push_addr;
      ent_data[tail_q] <= push_data;
      ent_be[tail_q]   <= push_be;
    end
  end

  assign full      = (count_q == CW'(DEPTH));
  assign empty     = (count_q == '0);
  assign head_idx  = head_q;
  assign ent_valid = valid_q;
  assign head_addr = ent_addr[head_q];
  assign head_data = ent_data[head_q];
  assign head_be   = ent_be[head_q];

  // R3: the requester never pushes into a full queue
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R5: only an occupied slot is ever removed
  a_r5_pop_occupied: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> valid_q[head_q]);

  // R2: occupancy bits and counter agree
  a_r2_count_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(valid_q) == int'(count_q));

endmodule

// File: rtl/sdb_match.sv
module sdb_match #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int BW   = DW / 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [AW-1:0]             rd_addr,
  input  logic [DEPTH-1:0]          ent_valid,
  input  logic [DEPTH-1:0][AW-1:0]  ent_addr,
  input  logic [DEPTH-1:0][DW-1:0]  ent_data,
  input  logic [DEPTH-1:0][BW-1:0]  ent_be,
  input  logic [PW-1:0]             head_idx,
  input  logic [DEPTH-1:0]          snap_mask,
  input  logic [DW-1:0]             mem_rdata,
  output logic [DEPTH-1:0]          hit_vec,
  output logic                      hit_any,
  output logic [DW-1:0]             rd_merged
);

  logic [DEPTH-1:0] addr_eq;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign addr_eq[i] = (ent_addr[i] == rd_addr);
    assign hit_vec[i] = ent_valid[i] & addr_eq[i];
  end

  assign hit_any = |hit_vec;

  // Walk oldest to youngest so the youngest enabled byte is written last.
  function automatic logic [DW-1:0] youngest_merge(
      input logic [DW-1:0]             base,
      input logic [DEPTH-1:0]          sel,
      input logic [DEPTH-1:0][DW-1:0]  data,
      input logic [DEPTH-1:0][BW-1:0]  be,
      input logic [PW-1:0]             head);
    logic [DW-1:0] acc;
    acc = base;
    for (int age = 0; age < DEPTH; age++) begin
      int idx;
      idx = (int'(head) + age) % DEPTH;
      if (sdb_pkg::ring_age(idx, int'(head), DEPTH) == age && sel[idx]) begin
        for (int b = 0; b < BW; b++) begin
          if (be[idx][b]) acc[b*8 +: 8] = data[idx][b*8 +: 8];
        end
      end
    end
    return acc;
  endfunction

  assign rd_merged = youngest_merge(mem_rdata, snap_mask & addr_eq,
                                    ent_data, ent_be, head_idx);

endmodule

// File: rtl/store_drain_buffer.sv
module store_drain_buffer #(
  parameter int AW      = 16,
  parameter int DW      = 32,
  parameter int DEPTH   = 4,
  parameter bit FORWARD = 1'b1,
  localparam int BW     = DW / 8,
  localparam int PW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  output logic          st_ready,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic [BW-1:0] st_be,
  input  logic          rd_valid,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_done,
  output logic [DW-1:0] rd_data,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic [BW-1:0] mem_be,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata
);
  import sdb_pkg::*;

  logic                      q_full, q_empty, q_push, q_pop;
  logic [PW-1:0]             head_idx;
  logic [DEPTH-1:0]          ent_valid, hit_vec, snap_q, snap_mask;
  logic [DEPTH-1:0][AW-1:0]  ent_addr;
  logic [DEPTH-1:0][DW-1:0]  ent_data;
  logic [DEPTH-1:0][BW-1:0]  ent_be;
  logic [AW-1:0]             head_addr;
  logic [DW-1:0]             head_data;
  logic [BW-1:0]             head_be;
  logic                      hit_any, rd_blocked, start_rd, start_wr;
  port_st_e                  state_q, state_d;

  assign st_ready = !q_full;
  assign q_push   = st_valid & st_ready;
  assign q_pop    = (state_q == PORT_WR) & mem_ack;

  sdb_fifo #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(q_push), .push_addr(st_addr), .push_data(st_data), .push_be(st_be),
    .pop(q_pop), .full(q_full), .empty(q_empty), .head_idx(head_idx),
    .ent_valid(ent_valid), .ent_addr(ent_addr), .ent_data(ent_data),
    .ent_be(ent_be), .head_addr(head_addr), .head_data(head_data),
    .head_be(head_be)
  );

  // Policy choice: forwarding merges the snapshot, draining never needs to.
  if (FORWARD) begin : g_fwd
    assign snap_mask  = snap_q;
    assign rd_blocked = 1'b0;
  end else begin : g_drain
    assign snap_mask  = '0;
    assign rd_blocked = hit_any;
  end

  sdb_match #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_match (
    .rd_addr(rd_addr), .ent_valid(ent_valid), .ent_addr(ent_addr),
    .ent_data(ent_data), .ent_be(ent_be), .head_idx(head_idx),
    .snap_mask(snap_mask), .mem_rdata(mem_rdata),
    .hit_vec(hit_vec), .hit_any(hit_any), .rd_merged(rd_data)
  );

  // Reads win the idle port; stores take it otherwise.
  assign start_rd = (state_q == PORT_IDLE) & rd_valid & !rd_blocked;
  assign start_wr = (state_q == PORT_IDLE) & !start_rd & !q_empty;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PORT_IDLE: if (start_rd) state_d = PORT_RD;
                 else if (start_wr) state_d = PORT_WR;
      PORT_WR,
      PORT_RD:   if (mem_ack) state_d = PORT_IDLE;
      default:   state_d = PORT_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= PORT_IDLE;
      snap_q  <= '0;
    end else begin
      state_q <= state_d;
      if (start_rd) snap_q <= ent_valid;
    end
  end

  assign mem_req   = (state_q != PORT_IDLE);
  assign mem_we    = (state_q == PORT_WR);
  assign mem_addr  = mem_we ? head_addr : rd_addr;
  assign mem_wdata = head_data;
  assign mem_be    = mem_we ? head_be : '1;
  assign rd_done   = (state_q == PORT_RD) & mem_ack;

  // R5: a request is held steady until memory takes it
  a_r5_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R7: the queue head is frozen while a read owns the port
  a_r7_head_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PORT_RD) |=> $stable(head_idx));

  // R9: in drain mode no read is in flight over a matching older store
  a_r9_no_hazard_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!FORWARD && state_q == PORT_RD) |-> ((snap_q & hit_vec) == '0));

  // R10: read completion lasts a single cycle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> !rd_done);

endmodule

// File: tb/store_drain_buffer_bench.sv
module sdb_mem_model #(
  parameter int AW  = 16,
  parameter int DW  = 32,
  parameter int LAT = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic            we,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  input  logic [DW/8-1:0] be,
  input  logic            hold,
  output logic            ack,
  output logic [DW-1:0]   rdata
);
  logic [DW-1:0] mem [16];
  logic [AW-1:0] log_addr [16];
  logic [DW-1:0] log_data [16];
  int cnt, wcnt, rcnt, wr_before_rd;

  assign rdata = mem[addr[3:0]];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] <= 32'hC0DE_0000 | i;
      ack <= 1'b0; cnt <= 0; wcnt <= 0; rcnt <= 0; wr_before_rd <= -1;
    end else begin
      if (ack && req) begin
        if (we) begin
          for (int b = 0; b < DW/8; b++)
            if (be[b]) mem[addr[3:0]][b*8 +: 8] <= wdata[b*8 +: 8];
          log_addr[wcnt[3:0]] <= addr;
          log_data[wcnt[3:0]] <= wdata;
          wcnt <= wcnt + 1;
        end else begin
          rcnt <= rcnt + 1;
          wr_before_rd <= wcnt;
        end
      end
      if (req && !ack && !hold) begin
        if (cnt == LAT - 1) begin ack <= 1'b1; cnt <= 0; end
        else cnt <= cnt + 1;
      end else begin
        ack <= 1'b0;
      end
    end
  end
endmodule

module store_drain_buffer_bench;
  localparam int AW = 16, DW = 32, BW = 4, DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          st_valid [2];
  logic          st_ready [2];
  logic [AW-1:0] st_addr  [2];
  logic [DW-1:0] st_data  [2];
  logic [BW-1:0] st_be    [2];
  logic          rd_valid [2];
  logic [AW-1:0] rd_addr  [2];
  logic          rd_done  [2];
  logic [DW-1:0] rd_data  [2];
  logic          mem_req  [2];
  logic          mem_we   [2];
  logic [AW-1:0] mem_addr [2];
  logic [DW-1:0] mem_wdata[2];
  logic [BW-1:0] mem_be   [2];
  logic          mem_ack  [2];
  logic [DW-1:0] mem_rdata[2];
  logic          hold     [2];

  for (genvar g = 0; g < 2; g++) begin : g_dut
    store_drain_buffer #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .FORWARD(g == 0))
      u_store_drain_buffer (
      .clk(clk), .rst_n(rst_n),
      .st_valid(st_valid[g]), .st_ready(st_ready[g]), .st_addr(st_addr[g]),
      .st_data(st_data[g]), .st_be(st_be[g]),
      .rd_valid(rd_valid[g]), .rd_addr(rd_addr[g]),
      .rd_done(rd_done[g]), .rd_data(rd_data[g]),
      .mem_req(mem_req[g]), .mem_we(mem_we[g]), .mem_addr(mem_addr[g]),
      .mem_wdata(mem_wdata[g]), .mem_be(mem_be[g]),
      .mem_ack(mem_ack[g]), .mem_rdata(mem_rdata[g])
    );
    sdb_mem_model #(.AW(AW), .DW(DW), .LAT(2)) u_mem (
      .clk(clk), .rst_n(rst_n), .req(mem_req[g]), .we(mem_we[g]),
      .addr(mem_addr[g]), .wdata(mem_wdata[g]), .be(mem_be[g]),
      .hold(hold[g]), .ack(mem_ack[g]), .rdata(mem_rdata[g])
    );
  end

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  task automatic check_eq(input string tag, input logic [31:0] act,
                          input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  function automatic int wcount(input int i);
    return (i == 0) ? g_dut[0].u_mem.wcnt : g_dut[1].u_mem.wcnt;
  endfunction
  function automatic int wr_before(input int i);
    return (i == 0) ? g_dut[0].u_mem.wr_before_rd : g_dut[1].u_mem.wr_before_rd;
  endfunction
  function automatic logic [AW-1:0] logged_addr(input int i, input int n);
    return (i == 0) ? g_dut[0].u_mem.log_addr[n] : g_dut[1].u_mem.log_addr[n];
  endfunction
  function automatic logic [DW-1:0] logged_data(input int i, input int n);
    return (i == 0) ? g_dut[0].u_mem.log_data[n] : g_dut[1].u_mem.log_data[n];
  endfunction

  task automatic push(input int i, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input logic [BW-1:0] be,
                      output bit acc);
    @(negedge clk);
    st_valid[i] = 1'b1; st_addr[i] = a; st_data[i] = d; st_be[i] = be;
    acc = st_ready[i];
    @(posedge clk); #1;
    st_valid[i] = 1'b0;
  endtask

  task automatic start_read(input int i, input logic [AW-1:0] a);
    @(negedge clk);
    rd_valid[i] = 1'b1; rd_addr[i] = a;
  endtask

  task automatic wait_read(input int i, output logic [DW-1:0] d);
    int n = 0;
    d = '0;
    forever begin
      @(negedge clk);
      if (rd_done[i]) break;
      if (++n > 200) begin
        errors++;
        $display("FAIL R10: read never completed, actual 0 expected 1");
        return;
      end
    end
    d = rd_data[i];
    rd_valid[i] = 1'b0;
    @(negedge clk);
    check_eq("R10 rd_done single cycle", 32'(rd_done[i]), 32'd0);
  endtask

  task automatic wait_writes(input int i, input int n);
    int t = 0;
    while (wcount(i) < n && t < 500) begin @(negedge clk); t++; end
  endtask

  task automatic t_reset();
    for (int i = 0; i < 2; i++) begin
      check_eq("R1 st_ready after reset", 32'(st_ready[i]), 32'd1);
      check_eq("R1 mem_req after reset", 32'(mem_req[i]), 32'd0);
      check_eq("R1 rd_done after reset", 32'(rd_done[i]), 32'd0);
    end
  endtask

  task automatic t_fill_and_order();
    bit acc;
    int accepted = 0;
    hold[0] = 1'b1;
    for (int k = 1; k <= 4; k++) begin
      push(0, AW'(k), 32'h1000_0000 | k, 4'hF, acc);
      accepted += int'(acc);
    end
    check_eq("R2 stores accepted while memory stalls", 32'(accepted), 32'd4);
    @(negedge clk);
    check_eq("R3 st_ready low when full", 32'(st_ready[0]), 32'd0);
    check_eq("R5 request addr held", 32'(mem_addr[0]), 32'd1);
    repeat (3) @(negedge clk);
    check_eq("R5 request still pending", {mem_req[0], mem_we[0], mem_addr[0]},
             {2'b11, 16'd1});
    hold[0] = 1'b0;
    wait_writes(0, 1);
    @(negedge clk);
    check_eq("R3 st_ready back after one ack", 32'(st_ready[0]), 32'd1);
    wait_writes(0, 4);
    for (int k = 0; k < 4; k++) begin
      check_eq("R4 write address order", 32'(logged_addr(0, k)), 32'(k + 1));
      check_eq("R4 write data order", logged_data(0, k), 32'h1000_0000 | (k + 1));
    end
  endtask

  task automatic t_bypass();
    bit acc;
    logic [DW-1:0] d;
    hold[0] = 1'b1;
    push(0, 16'd5, 32'h5555_5555, 4'hF, acc);
    push(0, 16'd6, 32'h6666_6666, 4'hF, acc);
    start_read(0, 16'd9);
    @(negedge clk);
    hold[0] = 1'b0;
    wait_read(0, d);
    check_eq("R8 unmatched read returns memory word", d, 32'hC0DE_0009);
    check_eq("R6 read overtakes queued store", 32'(wr_before(0)), 32'd5);
    wait_writes(0, 6);
    check_eq("R7 stores resume after read", 32'(logged_addr(0, 5)), 32'd6);
  endtask

  task automatic t_forward();
    bit acc;
    logic [DW-1:0] d;
    hold[0] = 1'b1;
    push(0, 16'd7, 32'h1122_3344, 4'hF, acc);
    push(0, 16'd8, 32'h8888_8888, 4'hF, acc);
    push(0, 16'd7, 32'hAABB_CCDD, 4'b0101, acc);
    start_read(0, 16'd7);
    @(negedge clk);
    hold[0] = 1'b0;
    wait_read(0, d);
    check_eq("R8 youngest bytes merged", d, 32'h11BB_33DD);
    check_eq("R8 forwarding read skips matching store", 32'(wr_before(0)), 32'd7);
    wait_writes(0, 9);
    hold[0] = 1'b1;
    push(0, 16'd12, 32'hCCCC_CCCC, 4'hF, acc);
    push(0, 16'd10, 32'h0000_EE00, 4'b0010, acc);
    start_read(0, 16'd10);
    @(negedge clk);
    hold[0] = 1'b0;
    wait_read(0, d);
    check_eq("R8 partial store patches memory word", d, 32'hC0DE_EE0A);
    wait_writes(0, 11);
  endtask

  task automatic t_drain();
    bit acc;
    logic [DW-1:0] d;
    hold[1] = 1'b1;
    push(1, 16'd1, 32'h0101_AAAA, 4'hF, acc);
    push(1, 16'd2, 32'h0202_BBBB, 4'hF, acc);
    push(1, 16'd3, 32'h0303_CCCC, 4'hF, acc);
    start_read(1, 16'd2);
    @(negedge clk);
    hold[1] = 1'b0;
    wait_read(1, d);
    check_eq("R9 drained data returned", d, 32'h0202_BBBB);
    check_eq("R9 read waits for matching store only", 32'(wr_before(1)), 32'd2);
    wait_writes(1, 3);
    check_eq("R7 last store written after read", 32'(logged_addr(1, 2)), 32'd3);
  endtask

  initial begin
    for (int i = 0; i < 2; i++) begin
      st_valid[i] = 1'b0; st_addr[i] = '0; st_data[i] = '0; st_be[i] = '0;
      rd_valid[i] = 1'b0; rd_addr[i] = '0; hold[i] = 1'b0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill_and_order();
    t_bypass();
    t_forward();
    t_drain();
    done_flag = 1'b1;
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

endmodule